// File: doc/BRIEF.md
# HDLC Status-Change Interrupt Controller

This block watches four status levels from an HDLC channel and turns their changes into one interrupt request. The four levels are abort, transmit underrun/end-of-message, hunt and idle detect. Each source has its own edge detector. The abort source reacts to a change in either direction. The other three react only when their level goes from 0 to 1. A qualifying edge on an enabled source sets that source's sticky pending flag. The interrupt output is high while any pending flag is set.

Software controls the per-source enables through two byte registers on a simple register bus. One register sets enable bits and the other clears them, and both act on the same enable state. A zero in either register leaves the matching bit unchanged. Reading either register returns the live enables. A third register shows the pending flags, and writing ones to it acknowledges them. The bit layout is the same in all three registers: D7 abort, D6 underrun/end-of-message, D5 hunt, D4 idle detect. Bits D3..D0 always read 0.

Top module: `hdlc_stat_irq`

## Requirements
- R1: After reset, the enable, pending and any other mapped register read 0, and `irq_o` is 0.
- R2: Writing to the set register (offset 0x04) sets the enable bits that are 1 in the write data. Bits written 0 keep their value. Reads at offset 0x04 and at offset 0x06 both return the current enables, with 1 meaning enabled.
- R3: Writing to the clear register (offset 0x06) clears the enable bits that are 1 in the write data. Bits written 0 keep their value.
- R4: While abort (D7) is enabled, a rising or a falling change of `abort_i` sets pending bit D7.
- R5: While each of them is enabled, a 0-to-1 change on `txu_eom_i` (D6), `hunt_i` (D5) or `idle_i` (D4) sets its pending bit. A 1-to-0 change sets nothing.
- R6: A qualifying edge on a disabled source sets no pending bit and leaves `irq_o` low.
- R7: A pending bit stays set until a 1 is written to it in the acknowledge register (offset 0x07). Zeros written there have no effect. Reads at offset 0x07 return the pending bits. `irq_o` is high exactly when at least one pending bit is set.
- R8: If a qualifying edge arrives in the same cycle as an acknowledge of the same bit, the bit stays set.
- R9: Bits D3..D0 of every register read 0 and ignore writes. Offsets other than 0x04, 0x06 and 0x07 read 0 and ignore writes.
- R10: A status change is sampled at the first rising clock edge after it occurs. The pending bit and `irq_o` show the change right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | Byte offset of the register access |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| abort_i | input | 1 | Abort status level |
| txu_eom_i | input | 1 | Transmit underrun / end-of-message status level |
| hunt_i | input | 1 | Hunt status level |
| idle_i | input | 1 | Idle detect status level |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The edge-detector assertions assume that the four status inputs are synchronous to `clk_i`. They also assume that the inputs are 0 while reset is active, so the first sampled level after reset is not taken as a real edge. The stimulus changes status levels and bus signals only on the falling clock edge and holds all status inputs at 0 through reset. It also issues at most one bus write per cycle, which is the only ordering between set and clear writes that the bus allows.

// File: rtl/hsirq_pkg.sv
package hsirq_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned SRC_LSB = 4;
  localparam logic [DATA_W-1:0] FIELD_MASK = 8'hF0;

  // source index: 0 idle (D4), 1 hunt (D5), 2 txu/eom (D6), 3 abort (D7)
  localparam int unsigned IDX_ABORT = 3;

  typedef enum logic [0:0] {
    EDGE_RISE = 1'b0,
    EDGE_ANY  = 1'b1
  } edge_mode_e;

  function automatic edge_mode_e src_mode(int unsigned idx);
    return (idx == IDX_ABORT) ? EDGE_ANY : EDGE_RISE;
  endfunction
endpackage

// File: rtl/hsirq_edge_det.sv
module hsirq_edge_det
  import hsirq_pkg::*;
#(
  parameter edge_mode_e MODE = EDGE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  generate
    if (MODE == EDGE_ANY) begin : g_any
      assign evt_o = lvl_i ^ prev_q;
      AST_ANY_EDGE_ONLY_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o |-> (lvl_i != $past(lvl_i))); // R4
    end else begin : g_rise
      assign evt_o = lvl_i & ~prev_q;
      AST_RISE_EDGE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o |-> (lvl_i && !$past(lvl_i))); // R5
    end
  endgenerate
endmodule

// File: rtl/hsirq_en_regs.sv
module hsirq_en_regs
  import hsirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_wr_i,
  input  logic              clr_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] en_o
);
  logic [DATA_W-1:0] en_q, set_mask, clr_mask;

  assign set_mask = set_wr_i ? (wdata_i & FIELD_MASK) : '0;
  assign clr_mask = clr_wr_i ? wdata_i : '0;

  // shared enable state: clear applied after set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_mask) & ~clr_mask & FIELD_MASK;
  end

  assign en_o = en_q;

  AST_SET_RAISES_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr_i && !clr_wr_i) |=> ((en_o & $past(wdata_i) & FIELD_MASK) == ($past(wdata_i) & FIELD_MASK))); // R2
  AST_CLR_DROPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i |=> ((en_o & $past(wdata_i)) == '0)); // R3
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_wr_i || clr_wr_i) |=> $stable(en_o)); // R2
endmodule

// File: rtl/hsirq_pend.sv
module hsirq_pend
  import hsirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] evt_i,
  input  logic [DATA_W-1:0] en_i,
  input  logic              ack_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] pend_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] pend_q, ack_mask, hit;

  assign ack_mask = ack_wr_i ? wdata_i : '0;
  assign hit      = evt_i & en_i & FIELD_MASK;

  // a new hit outranks a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~ack_mask) | hit;
  end

  assign pend_o = pend_q;
  assign irq_o  = |pend_q;

  AST_PEND_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(en_i)) == '0)); // R6
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_wr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_wr_i |=> ((pend_q & $past(wdata_i) & ~$past(evt_i)) == '0)); // R7
  AST_HIT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_wr_i |=> ((pend_q & $past(evt_i) & $past(en_i) & FIELD_MASK) == ($past(evt_i) & $past(en_i) & FIELD_MASK))); // R8
endmodule

// File: rtl/hdlc_stat_irq.sv
module hdlc_stat_irq
  import hsirq_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] OFS_SET = 8'h04,
  parameter logic [ADDR_W-1:0] OFS_CLR = 8'h06,
  parameter logic [ADDR_W-1:0] OFS_ACK = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              abort_i,
  input  logic              txu_eom_i,
  input  logic              hunt_i,
  input  logic              idle_i,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] lvl, evt4;
  logic [DATA_W-1:0]  evt, en, pend;
  logic               set_wr, clr_wr, ack_wr;

  assign lvl    = {abort_i, txu_eom_i, hunt_i, idle_i};
  assign set_wr = we_i && (addr_i == OFS_SET);
  assign clr_wr = we_i && (addr_i == OFS_CLR);
  assign ack_wr = we_i && (addr_i == OFS_ACK);

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      hsirq_edge_det #(.MODE(src_mode(i))) u_edge (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (lvl[i]),
        .evt_o (evt4[i])
      );
    end
  endgenerate

  assign evt = {evt4, {SRC_LSB{1'b0}}};

  hsirq_en_regs u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_wr_i(set_wr),
    .clr_wr_i(clr_wr),
    .wdata_i (wdata_i),
    .en_o    (en)
  );

  hsirq_pend u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .en_i    (en),
    .ack_wr_i(ack_wr),
    .wdata_i (wdata_i),
    .pend_o  (pend),
    .irq_o   (irq_o)
  );

  always_comb begin
    if (addr_i == OFS_SET || addr_i == OFS_CLR) rdata_o = en;
    else if (addr_i == OFS_ACK)                 rdata_o = pend;
    else                                        rdata_o = '0;
  end

  AST_IRQ_FOLLOWS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt & en) != '0) |=> irq_o); // R10
  AST_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[SRC_LSB-1:0] == '0); // R9
endmodule

// File: tb/hdlc_stat_irq_tb.sv
module hdlc_stat_irq_tb_top;
  localparam logic [7:0] A_SET = 8'h04, A_CLR = 8'h06, A_ACK = 8'h07;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       we = 1'b0, ab = 1'b0, tx = 1'b0, hu = 1'b0, id = 1'b0, irq;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  hdlc_stat_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .abort_i(ab), .txu_eom_i(tx), .hunt_i(hu), .idle_i(id),
    .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr = a; #1 chk(req, rdata, exp);
  endtask

  task automatic stat(input logic a, input logic t, input logic h, input logic i);
    @(negedge clk); ab = a; tx = t; hu = h; id = i;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rd_chk("R1 set reg", A_SET, 8'h00);
    rd_chk("R1 clr reg", A_CLR, 8'h00);
    rd_chk("R1 pend reg", A_ACK, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_set_clear();
    wr(A_SET, 8'hF0); rd_chk("R2 set read", A_SET, 8'hF0);
    rd_chk("R2 clr read mirrors", A_CLR, 8'hF0);
    wr(A_SET, 8'h0F); rd_chk("R9 low bits ignored", A_SET, 8'hF0);
    wr(A_CLR, 8'h00); rd_chk("R3 zero clr no effect", A_CLR, 8'hF0);
    wr(A_CLR, 8'h80); rd_chk("R3 clr abort", A_CLR, 8'h70);
    wr(A_SET, 8'h00); rd_chk("R2 zero set no effect", A_SET, 8'h70);
    wr(A_CLR, 8'h70); rd_chk("R3 clr rest", A_SET, 8'h00);
  endtask

  task automatic t_abort();
    wr(A_SET, 8'h80);
    @(negedge clk); ab = 1'b1; #1;
    chk("R10 no irq before edge", {7'd0, irq}, 8'h00);
    @(posedge clk); #1;
    chk("R10 irq after edge", {7'd0, irq}, 8'h01);
    rd_chk("R4 abort rise", A_ACK, 8'h80);
    wr(A_ACK, 8'h80); rd_chk("R7 ack abort", A_ACK, 8'h00);
    chk("R7 irq low after ack", {7'd0, irq}, 8'h00);
    stat(1'b0, 1'b0, 1'b0, 1'b0);
    rd_chk("R4 abort fall", A_ACK, 8'h80);
    wr(A_ACK, 8'h80); wr(A_CLR, 8'hF0);
  endtask

  task automatic t_rising();
    wr(A_SET, 8'h70);
    stat(1'b0, 1'b1, 1'b0, 1'b0); rd_chk("R5 txu rise", A_ACK, 8'h40);
    wr(A_ACK, 8'h40);
    stat(1'b0, 1'b0, 1'b0, 1'b0); rd_chk("R5 txu fall ignored", A_ACK, 8'h00);
    stat(1'b0, 1'b0, 1'b1, 1'b0); rd_chk("R5 hunt rise", A_ACK, 8'h20);
    wr(A_ACK, 8'h20);
    stat(1'b0, 1'b0, 1'b0, 1'b0); rd_chk("R5 hunt fall ignored", A_ACK, 8'h00);
    stat(1'b0, 1'b0, 1'b0, 1'b1); rd_chk("R5 idle rise", A_ACK, 8'h10);
    wr(A_ACK, 8'h10);
    stat(1'b0, 1'b0, 1'b0, 1'b0); rd_chk("R5 idle fall ignored", A_ACK, 8'h00);
    chk("R5 irq stays low", {7'd0, irq}, 8'h00);
    wr(A_CLR, 8'hF0);
  endtask

  task automatic t_disabled();
    stat(1'b1, 1'b1, 1'b1, 1'b1);
    rd_chk("R6 rise while disabled", A_ACK, 8'h00);
    stat(1'b0, 1'b0, 1'b0, 1'b0);
    rd_chk("R6 fall while disabled", A_ACK, 8'h00);
    chk("R6 irq low", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_ack();
    wr(A_SET, 8'h30);
    stat(1'b0, 1'b0, 1'b1, 1'b1); rd_chk("R7 two pending", A_ACK, 8'h30);
    wr(A_ACK, 8'h00); rd_chk("R7 zero ack no effect", A_ACK, 8'h30);
    wr(A_ACK, 8'h20); rd_chk("R7 partial ack", A_ACK, 8'h10);
    chk("R7 irq with one pending", {7'd0, irq}, 8'h01);
    wr(A_ACK, 8'h10); chk("R7 irq drops", {7'd0, irq}, 8'h00);
    stat(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_race();
    stat(1'b0, 1'b0, 1'b1, 1'b0); rd_chk("R8 setup", A_ACK, 8'h20);
    stat(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); hu = 1'b1; addr = A_ACK; wdata = 8'h20; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
    rd_chk("R8 edge beats ack", A_ACK, 8'h20);
    wr(A_ACK, 8'h20); wr(A_CLR, 8'hF0);
    stat(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_unmapped();
    wr(A_SET, 8'h50);
    wr(8'h00, 8'hFF); rd_chk("R9 unmapped read", 8'h00, 8'h00);
    wr(8'h05, 8'hFF); rd_chk("R9 unmapped write ignored", A_SET, 8'h50);
    rd_chk("R9 pend untouched", A_ACK, 8'h00);
    wr(A_CLR, 8'hFF);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_set_clear();
    t_abort();
    t_rising();
    t_disabled();
    t_ack();
    t_race();
    t_unmapped();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule